// File: doc/BRIEF.md
# Post-Trigger Sample Counter

This block counts the samples that are still captured after a trigger. A processor presets it with a 16-bit value through a synchronous parallel load. In write mode it then advances by one on every sample-clock edge while the active-low count-start input from the trigger logic is held low. When the count reaches the all-ones terminal value, the active-low stop output drops. Stop is what freezes the sample-memory address counter elsewhere in the system. Stop also feeds back into this block and cancels its own count request, so the count parks at the terminal value.

Stop stays low through any change of mode. It rises only when the processor loads a value other than the terminal count. Software therefore preloads a non-terminal value before it walks the sample memory in read mode.

A small state machine reports the counter's phase. `PH_READ` (0) means read mode. `PH_ARMED` (1) means write mode with the count idle. `PH_RUN` (2) means the counter advanced on the last edge. `PH_DONE` (3) means write mode with the count at its terminal value. Every edge picks the next phase from the same rules, whatever the current phase. Leaving write mode goes to `PH_READ`. Otherwise a terminal next count goes to `PH_DONE`. Otherwise an increment goes to `PH_RUN`. Otherwise the phase is `PH_ARMED`.

Top module: `post_trig_counter`

## Requirements
- R1: A synchronous active-high reset sets the count to 0, holds stop_n high and sets phase to PH_READ (0).
- R2: In write mode (wr_mode=1), with start_n low, stop_n high and no load, the count rises by exactly one on each clock edge, starting with the first edge at which start_n is seen low.
- R3: In read mode (wr_mode=0) the count never advances, whatever the level of start_n.
- R4: stop_n is low in exactly the cycles in which the count equals 65535 (all ones), with no register delay after the count.
- R5: While stop_n is low, the count request is blocked, so the count holds at 65535 even with write mode and start_n low.
- R6: Once low, stop_n stays low across changes of wr_mode until a load occurs.
- R7: With ld_en high, ld_val appears on the count at the next edge, ahead of any increment. Loading a value other than 65535 raises stop_n after that edge. Loading 65535 leaves stop_n low.
- R8: In write mode with start_n high, the count holds.
- R9: After each edge, phase is 0 in read mode. In write mode it is 3 if the count is 65535, otherwise 2 if the count advanced on that edge, otherwise 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sample clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_mode | input | 1 | 1 = write (capture) mode, 0 = read mode |
| start_n | input | 1 | Active-low count-start request from trigger logic |
| ld_en | input | 1 | Load strobe for the preset value |
| ld_val | input | 16 | Preset value |
| cnt_o | output | 16 | Current count |
| stop_n | output | 1 | Active-low terminal-count stop |
| phase | output | 2 | Phase code (0 read, 1 armed, 2 run, 3 done) |

## Verification
The count and the phase are registered, so each is due one edge after the inputs that caused it. Stop is combinational from the count, so it is due in the same cycle as that count. The bench drives every input on the falling edge and pushes the expected count, stop and phase for that stimulus into a queue. The monitor pops one item a short time after the following rising edge and compares all three values in that cycle.

// File: rtl/ptc_pkg.sv
package ptc_pkg;
    typedef enum logic [1:0] {
        PH_READ  = 2'd0,
        PH_ARMED = 2'd1,
        PH_RUN   = 2'd2,
        PH_DONE  = 2'd3
    } ptc_phase_e;
endpackage

// File: rtl/ptc_counter.sv
module ptc_counter #(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             cnt_en,
    input  logic             ld_en,
    input  logic [CNT_W-1:0] ld_val,
    output logic [CNT_W-1:0] cnt_q,
    output logic             at_tc,
    output logic             nxt_tc
);
    localparam logic [CNT_W-1:0] TERM = {CNT_W{1'b1}};

    logic [CNT_W-1:0] cnt_d;

    always_comb begin
        if (ld_en)       cnt_d = ld_val;
        else if (cnt_en) cnt_d = cnt_q + 1'b1;
        else             cnt_d = cnt_q;
    end

    always_ff @(posedge clk) begin
        if (rst) cnt_q <= '0;
        else     cnt_q <= cnt_d;
    end

    assign at_tc  = (cnt_q == TERM);
    assign nxt_tc = (cnt_d == TERM);

    // R7
    load_takes_chk: assert property (@(posedge clk) disable iff (rst)
        ld_en |=> (cnt_q == $past(ld_val)));

    // R5
    tc_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (at_tc && !ld_en) |=> (cnt_q == TERM));
endmodule

// File: rtl/ptc_ctrl.sv
module ptc_ctrl
    import ptc_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       wr_mode,
    input  logic       start_n,
    input  logic       ld_en,
    input  logic       stop_n,
    input  logic       nxt_tc,
    output logic       cnt_en,
    output ptc_phase_e state_q
);
    ptc_phase_e state_d;

    // stop_n low masks the start request
    always_comb begin
        cnt_en = wr_mode && !start_n && stop_n && !ld_en;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            PH_READ: begin
                if (!wr_mode)    state_d = PH_READ;
                else if (nxt_tc) state_d = PH_DONE;
                else if (cnt_en) state_d = PH_RUN;
                else             state_d = PH_ARMED;
            end
            PH_ARMED: begin
                if (!wr_mode)    state_d = PH_READ;
                else if (nxt_tc) state_d = PH_DONE;
                else if (cnt_en) state_d = PH_RUN;
                else             state_d = PH_ARMED;
            end
            PH_RUN: begin
                if (!wr_mode)    state_d = PH_READ;
                else if (nxt_tc) state_d = PH_DONE;
                else if (cnt_en) state_d = PH_RUN;
                else             state_d = PH_ARMED;
            end
            PH_DONE: begin
                if (!wr_mode)    state_d = PH_READ;
                else if (nxt_tc) state_d = PH_DONE;
                else if (cnt_en) state_d = PH_RUN;
                else             state_d = PH_ARMED;
            end
            default: state_d = PH_READ;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) state_q <= PH_READ;
        else     state_q <= state_d;
    end

    // R6
    stop_sticky_chk: assert property (@(posedge clk) disable iff (rst)
        (!stop_n && !ld_en) |=> !stop_n);

    // R9
    read_phase_chk: assert property (@(posedge clk) disable iff (rst)
        !wr_mode |=> (state_q == PH_READ));
endmodule

// File: rtl/post_trig_counter.sv
module post_trig_counter
    import ptc_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             wr_mode,
    input  logic             start_n,
    input  logic             ld_en,
    input  logic [CNT_W-1:0] ld_val,
    output logic [CNT_W-1:0] cnt_o,
    output logic             stop_n,
    output logic [1:0]       phase
);
    logic       cnt_en;
    logic       at_tc;
    logic       nxt_tc;
    ptc_phase_e st;

    ptc_counter #(.CNT_W(CNT_W)) u_cnt (
        .clk    (clk),
        .rst    (rst),
        .cnt_en (cnt_en),
        .ld_en  (ld_en),
        .ld_val (ld_val),
        .cnt_q  (cnt_o),
        .at_tc  (at_tc),
        .nxt_tc (nxt_tc)
    );

    ptc_ctrl u_ctrl (
        .clk     (clk),
        .rst     (rst),
        .wr_mode (wr_mode),
        .start_n (start_n),
        .ld_en   (ld_en),
        .stop_n  (stop_n),
        .nxt_tc  (nxt_tc),
        .cnt_en  (cnt_en),
        .state_q (st)
    );

    assign stop_n = !at_tc;
    assign phase  = st;

    // R3
    read_frozen_chk: assert property (@(posedge clk) disable iff (rst)
        (!wr_mode && !ld_en) |=> $stable(cnt_o));

    // R8
    idle_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (start_n && !ld_en) |=> $stable(cnt_o));
endmodule

// File: tb/post_trig_counter_tb.sv
module post_trig_counter_tb_top;
    typedef struct packed {
        logic [15:0] cnt;
        logic        stp;
        logic [1:0]  ph;
        logic [7:0]  req;
    } exp_t;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        wr_mode = 1'b0;
    logic        start_n = 1'b1;
    logic        ld_en = 1'b0;
    logic [15:0] ld_val = '0;
    logic [15:0] cnt_o;
    logic        stop_n;
    logic [1:0]  phase;

    int n_chk = 0;
    int n_bad = 0;
    exp_t q[$];
    logic [15:0] m_cnt = '0;
    bit done = 0;

    always #4 clk = ~clk;

    post_trig_counter dut_i (
        .clk(clk), .rst(rst), .wr_mode(wr_mode), .start_n(start_n),
        .ld_en(ld_en), .ld_val(ld_val), .cnt_o(cnt_o), .stop_n(stop_n),
        .phase(phase)
    );

    task automatic step(input logic wr, input logic st, input logic ld,
                        input logic [15:0] v, input int rq);
        exp_t e;
        logic adv;
        @(negedge clk);
        wr_mode = wr; start_n = st; ld_en = ld; ld_val = v;
        adv = 1'b0;
        if (ld) m_cnt = v;
        else if (wr && !st && m_cnt != 16'hFFFF) begin
            m_cnt = m_cnt + 16'd1; adv = 1'b1;
        end
        e.cnt = m_cnt;
        e.stp = (m_cnt != 16'hFFFF);
        e.ph  = !wr ? 2'd0 : (m_cnt == 16'hFFFF) ? 2'd3 : adv ? 2'd2 : 2'd1;
        e.req = 8'(rq);
        q.push_back(e);
    endtask

    always @(posedge clk) begin
        #2;
        if (q.size() > 0) begin
            exp_t e;
            e = q.pop_front();
            n_chk++;
            if (cnt_o !== e.cnt || stop_n !== e.stp || phase !== e.ph) begin
                n_bad++;
                $display("FAIL R%0d: cnt=%0d stop_n=%0b phase=%0d expected cnt=%0d stop_n=%0b phase=%0d",
                         e.req, cnt_o, stop_n, phase, e.cnt, e.stp, e.ph);
            end
        end
    end

    initial begin
        int wd;
        for (wd = 0; wd < 5000 && !done; wd++) @(posedge clk);
        if (!done) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog: run hung, expected completion");
            $display("test done: total=%0d bad=%0d", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        #2;
        // R1 reset state
        n_chk++;
        if (cnt_o !== 16'd0 || stop_n !== 1'b1 || phase !== 2'd0) begin
            n_bad++;
            $display("FAIL R1: cnt=%0d stop_n=%0b phase=%0d expected 0 1 0", cnt_o, stop_n, phase);
        end
        @(negedge clk); rst = 1'b0;
        // R3 read mode with start low: no counting
        for (int i = 0; i < 3; i++) step(1'b0, 1'b0, 1'b0, 16'd0, 3);
        // R8 write mode, start high: hold
        for (int i = 0; i < 3; i++) step(1'b1, 1'b1, 1'b0, 16'd0, 8);
        // R2 counting from first low edge
        for (int i = 0; i < 5; i++) step(1'b1, 1'b0, 1'b0, 16'd0, 2);
        // R8 pause mid-run, R9 armed phase
        step(1'b1, 1'b1, 1'b0, 16'd0, 9);
        step(1'b1, 1'b0, 1'b0, 16'd0, 2);
        // R7 preset near terminal in read mode
        step(1'b0, 1'b1, 1'b1, 16'd65532, 7);
        // R4 reach terminal, R5 then hold
        for (int i = 0; i < 3; i++) step(1'b1, 1'b0, 1'b0, 16'd0, 4);
        for (int i = 0; i < 3; i++) step(1'b1, 1'b0, 1'b0, 16'd0, 5);
        // R6 stop sticky across mode changes
        for (int i = 0; i < 2; i++) step(1'b0, 1'b0, 1'b0, 16'd0, 6);
        step(1'b1, 1'b1, 1'b0, 16'd0, 6);
        step(1'b0, 1'b1, 1'b0, 16'd0, 6);
        // R7 loading terminal keeps stop low
        step(1'b0, 1'b1, 1'b1, 16'hFFFF, 7);
        step(1'b1, 1'b0, 1'b0, 16'd0, 5);
        // R7 load beats counting in write mode, releases stop
        step(1'b1, 1'b0, 1'b1, 16'd100, 7);
        for (int i = 0; i < 3; i++) step(1'b1, 1'b0, 1'b0, 16'd0, 2);
        // R7 load terminal directly in write mode -> done phase
        step(1'b1, 1'b0, 1'b1, 16'hFFFF, 9);
        step(1'b0, 1'b1, 1'b1, 16'd0, 7);
        step(1'b1, 1'b1, 1'b0, 16'd0, 9);
        step(1'b0, 1'b1, 1'b0, 16'd0, 3);
        @(negedge clk);
        @(negedge clk);
        done = 1;
        $display("test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end
endmodule